// File: doc/BRIEF.md
# Stochastic GF(2^p) Variable Node with Edge Memories

This block is one variable node of a stochastic decoder for nonbinary LDPC codes over GF(2^p). Each decoding beat carries one p-bit field symbol on each of its `DEG` input edges. For every output edge the node looks at the symbols on all the other input edges. When they are all the same symbol, that symbol is the new output for the edge, and it is also pushed into the edge's memory. When they are not all the same, the edge's memory is left as it is and the output is a stored symbol picked by an external random index.

Each edge memory is a shift buffer of `MEM_LEN` symbols. Before decoding starts, a load port writes chosen slots so that the stored symbols follow the scaled channel likelihoods. Outputs are registered and appear one clock after the beat that produced them.

Top module: `stoch_var_node`

## Requirements
- R1: After reset every output symbol is 0, `out_valid_o` is 0, and every memory slot holds 0. A random read straight after reset therefore returns 0.
- R2: `out_valid_o` is 1 in the cycle after a beat (`in_valid_i`=1 with `init_load_i`=0) and 0 otherwise.
- R3: If every input edge other than e carries the same symbol a in a beat, output edge e shows a one cycle later.
- R4: That agreement writes a into slot 0 of edge e's memory. Slot k receives the old slot k-1, and the old slot `MEM_LEN`-1 is lost.
- R5: If the other edges of e do not all agree, output e shows slot `rnd_idx` of e's memory as it was before the beat, and the memory does not change.
- R6: A random index or load pointer of value `MEM_LEN` or more addresses slot value-`MEM_LEN`.
- R7: A cycle with `init_load_i`=1 writes `init_sym_i` into slot `init_ptr_i` (after R6 folding) of edge `init_edge_i`. An edge number of `DEG` or more changes nothing.
- R8: While `init_load_i` is 1, `in_valid_i` is ignored. The outputs hold, `out_valid_o` is 0 the next cycle, and no shift happens.
- R9: In a cycle without a beat, the output symbols hold their values.
- R10: Equality covers the whole symbol. Inputs that differ in any single bit count as disagreement.
- R11: Symbols are packed with edge e on bits [e*`SYM_W` +: `SYM_W`]. Random indices are packed with edge e on bits [e*`IDX_W` +: `IDX_W`], where `IDX_W`=ceil(log2 `MEM_LEN`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoding beat present |
| in_sym_i | input | DEG*SYM_W | Incoming symbols, one per edge |
| rnd_idx_i | input | DEG*IDX_W | Random read index, one per edge |
| init_load_i | input | 1 | Memory load strobe |
| init_edge_i | input | EDGE_W | Edge selected for load |
| init_ptr_i | input | IDX_W | Slot selected for load |
| init_sym_i | input | SYM_W | Symbol to load |
| out_valid_o | output | 1 | Output symbols belong to a beat |
| out_sym_o | output | DEG*SYM_W | Outgoing symbols, one per edge |

## Verification
A wrong memory word stays hidden until the edge's agreement condition fails and the random index lands on that slot. The bench therefore sweeps every index over every edge after each load or shift, so a bad slot shows at the outputs within one read sweep. A shift-order or drop error shows only after `MEM_LEN` further agreements, so the bench fills a memory to capacity and reads it back. A wrong agreement decision shows on the very next output, and the bench exercises it exhaustively over every input combination of a small field.

// File: rtl/svn_pkg.sv
package svn_pkg;
  // Fold an index in [0, 2*len) into [0, len).
  function automatic int unsigned fold_idx(input int unsigned idx, input int unsigned len);
    return (idx >= len) ? idx - len : idx;
  endfunction
endpackage

// File: rtl/svn_eq_detect.sv
module svn_eq_detect #(
  parameter int SYM_W = 4,
  parameter int DEG   = 4
) (
  input  logic [DEG-1:0][SYM_W-1:0] sym_i,
  output logic [DEG-1:0]            agree_o
);
  for (genvar e = 0; e < DEG; e++) begin : g_edge
    localparam int REF = (e == 0) ? 1 : 0;
    logic [DEG-1:0] match;
    for (genvar k = 0; k < DEG; k++) begin : g_cmp
      if (k == e || k == REF) begin : g_skip
        assign match[k] = 1'b1;
      end else begin : g_xnor
        assign match[k] = &(sym_i[k] ~^ sym_i[REF]);
      end
    end
    assign agree_o[e] = &match;
  end
endmodule

// File: rtl/svn_edge_mem.sv
module svn_edge_mem
  import svn_pkg::*;
#(
  parameter int SYM_W   = 4,
  parameter int MEM_LEN = 50,
  parameter int IDX_W   = $clog2(MEM_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             agree_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic [IDX_W-1:0] rnd_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_ptr_i,
  input  logic [SYM_W-1:0] wr_sym_i,
  output logic [SYM_W-1:0] out_sym_o
);
  logic [MEM_LEN-1:0][SYM_W-1:0] mem_q;
  logic [IDX_W-1:0] rd_slot, wr_slot;

  always_comb begin
    rd_slot = IDX_W'(fold_idx(int'(rnd_idx_i), MEM_LEN));
    wr_slot = IDX_W'(fold_idx(int'(wr_ptr_i), MEM_LEN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q     <= '0;
      out_sym_o <= '0;
    end else begin
      if (wr_en_i) begin
        mem_q[wr_slot] <= wr_sym_i;
      end else if (beat_i && agree_i) begin
        mem_q <= {mem_q[MEM_LEN-2:0], sym_i};
      end
      if (beat_i) begin
        out_sym_o <= agree_i ? sym_i : mem_q[rd_slot];
      end
    end
  end

  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && agree_i |=> out_sym_o == $past(sym_i));
  p_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && agree_i && !wr_en_i |=> mem_q[0] == $past(sym_i) && mem_q[1] == $past(mem_q[0]));
  p_mem_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !agree_i && !wr_en_i |=> $stable(mem_q));
  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_i |=> $stable(out_sym_o));
endmodule

// File: rtl/stoch_var_node.sv
module stoch_var_node #(
  parameter int SYM_W   = 4,
  parameter int DEG     = 4,
  parameter int MEM_LEN = 50,
  localparam int IDX_W  = $clog2(MEM_LEN),
  localparam int EDGE_W = (DEG > 1) ? $clog2(DEG) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [DEG*SYM_W-1:0] in_sym_i,
  input  logic [DEG*IDX_W-1:0] rnd_idx_i,
  input  logic                 init_load_i,
  input  logic [EDGE_W-1:0]    init_edge_i,
  input  logic [IDX_W-1:0]     init_ptr_i,
  input  logic [SYM_W-1:0]     init_sym_i,
  output logic                 out_valid_o,
  output logic [DEG*SYM_W-1:0] out_sym_o
);
  logic [DEG-1:0][SYM_W-1:0] sym;
  logic [DEG-1:0]            agree;
  logic                      beat;

  assign sym  = in_sym_i;
  assign beat = in_valid_i && !init_load_i;

  svn_eq_detect #(.SYM_W(SYM_W), .DEG(DEG)) u_eq (
    .sym_i  (sym),
    .agree_o(agree)
  );

  for (genvar e = 0; e < DEG; e++) begin : g_mem
    logic wr_en;
    assign wr_en = init_load_i && (int'(init_edge_i) == e);
    svn_edge_mem #(.SYM_W(SYM_W), .MEM_LEN(MEM_LEN), .IDX_W(IDX_W)) u_mem (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .beat_i   (beat),
      .agree_i  (agree[e]),
      .sym_i    (sym[e]),
      .rnd_idx_i(rnd_idx_i[e*IDX_W +: IDX_W]),
      .wr_en_i  (wr_en),
      .wr_ptr_i (init_ptr_i),
      .wr_sym_i (init_sym_i),
      .out_sym_o(out_sym_o[e*SYM_W +: SYM_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= beat;
  end

  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !init_load_i |=> out_valid_o);
  p_load_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_load_i |=> !out_valid_o && $stable(out_sym_o));
  p_uniform_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat && in_sym_i == {DEG{in_sym_i[SYM_W-1:0]}} |=> out_sym_o == $past(in_sym_i));
endmodule

// File: tb/sim_stoch_var_node.sv
module sim_stoch_var_node;
  localparam int SW = 3, DG = 3, ML = 5, IW = 3, EW = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, init_load = 0;
  logic [DG*SW-1:0] in_sym = '0;
  logic [DG*IW-1:0] rnd = '0;
  logic [EW-1:0] init_edge = '0;
  logic [IW-1:0] init_ptr = '0;
  logic [SW-1:0] init_sym = '0;
  logic out_valid;
  logic [DG*SW-1:0] out_sym;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [SW-1:0] mdl [DG][ML];
  logic [SW-1:0] exp_out [DG];
  logic exp_valid;

  always #2 clk = ~clk;

  stoch_var_node #(.SYM_W(SW), .DEG(DG), .MEM_LEN(ML)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sym_i(in_sym),
    .rnd_idx_i(rnd), .init_load_i(init_load), .init_edge_i(init_edge),
    .init_ptr_i(init_ptr), .init_sym_i(init_sym), .out_valid_o(out_valid),
    .out_sym_o(out_sym));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check(out_valid === exp_valid, {tag, " valid"}, int'(out_valid), int'(exp_valid));
    for (int e = 0; e < DG; e++)
      check(out_sym[e*SW +: SW] === exp_out[e], tag, int'(out_sym[e*SW +: SW]), int'(exp_out[e]));
  endtask

  // One clock: drive at negedge, update the model at posedge, compare just after.
  task automatic cyc(input bit v, input logic [DG*SW-1:0] s, input logic [DG*IW-1:0] r,
                     input bit il, input int ie, input int ip, input int isym, input string tag);
    @(negedge clk);
    in_valid = v; in_sym = s; rnd = r; init_load = il;
    init_edge = EW'(ie); init_ptr = IW'(ip); init_sym = SW'(isym);
    @(posedge clk);
    if (il) begin
      if (ie < DG) mdl[ie][(ip >= ML) ? ip - ML : ip] = SW'(isym);
    end else if (v) begin
      logic [SW-1:0] nm [DG][ML];
      nm = mdl;
      for (int e = 0; e < DG; e++) begin
        bit ag = 1;
        int rf = (e == 0) ? 1 : 0;
        int ix = int'(r[e*IW +: IW]);
        for (int k = 0; k < DG; k++)
          if (k != e && s[k*SW +: SW] != s[rf*SW +: SW]) ag = 0;
        if (ix >= ML) ix -= ML;
        if (ag) begin
          exp_out[e] = s[e*SW +: SW];
          for (int j = ML - 1; j > 0; j--) nm[e][j] = mdl[e][j-1];
          nm[e][0] = s[e*SW +: SW];
        end else begin
          exp_out[e] = mdl[e][ix];
        end
      end
      mdl = nm;
    end
    exp_valid = v && !il;
    #1;
    check_outs(tag);
  endtask

  function automatic logic [DG*IW-1:0] all_idx(input int i);
    return {DG{IW'(i)}};
  endfunction

  // Disagreeing inputs for every edge: all three distinct.
  localparam logic [DG*SW-1:0] DIS = {3'd2, 3'd1, 3'd0};

  task automatic read_sweep(input string tag);
    for (int i = 0; i < 8; i++) cyc(1, DIS, all_idx(i), 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int e = 0; e < DG; e++) begin
      exp_out[e] = '0;
      for (int j = 0; j < ML; j++) mdl[e][j] = '0;
    end
    exp_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    check_outs("R1 reset");
    @(negedge clk) rst_n = 1;
    read_sweep("R1 cleared memory");

    // R7: fill every slot, including pointers folded by R6.
    for (int e = 0; e < DG; e++)
      for (int j = 0; j < ML; j++)
        cyc(0, '0, '0, 1, e, (j < 3) ? j + ML : j, (e * 5 + j + 1) % 8, "R7 R6 load");
    read_sweep("R7 R5 R6 readback");

    // R7: edge number >= DEG is ignored.
    cyc(0, '0, '0, 1, 3, 0, 7, "R7 bad edge");
    read_sweep("R7 bad edge readback");

    // R8: load with in_valid high; no beat, load still lands.
    cyc(1, {3'd4, 3'd4, 3'd4}, '0, 1, 1, 2, 6, "R8 load blocks beat");
    read_sweep("R8 readback");

    // R9: idle cycles hold outputs.
    cyc(0, {3'd5, 3'd5, 3'd5}, '0, 0, 0, 0, 0, "R9 idle");
    cyc(0, {3'd1, 3'd2, 3'd3}, all_idx(3), 0, 0, 0, 0, "R9 idle");

    // R4: fill edges with 1..5, then one more push drops the oldest.
    for (int v = 1; v <= ML; v++) cyc(1, {DG{SW'(v)}}, '0, 0, 0, 0, 0, "R3 R4 fill");
    read_sweep("R4 order");
    cyc(1, {DG{3'd6}}, '0, 0, 0, 0, 0, "R3 R4 push");
    read_sweep("R4 drop oldest");

    // R10: single bit differences break agreement.
    for (int b = 0; b < SW; b++)
      cyc(1, {3'd5, 3'd5 ^ SW'(1 << b), 3'd5}, all_idx(b + 1), 0, 0, 0, 0, "R10 bit diff");
    read_sweep("R10 readback");

    // R3/R5/R6/R11: exhaustive sweep over all input symbol triples.
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++)
          cyc(1, {SW'(c), SW'(b), SW'(a)},
              {IW'((a + c) & 7), IW'((b + 2 * c) & 7), IW'((a + b + c) & 7)},
              0, 0, 0, 0, "R3 R5 R6 R11 sweep");
    read_sweep("R2 R5 final readback");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule